// File: doc/BRIEF.md
# Keyed Watchdog Timer with Free-Running Prescaler

The block watches for a stalled processor. A prescaler driven by the system clock runs freely from reset release and splits the selected detection time into four equal quarters. A small binary counter advances once per quarter and overflows on its fourth advance. Software keeps the system alive by writing a fixed key value to a clear address often enough. That write restarts only the binary counter. The prescaler keeps its phase, so the real time from a clear to an overflow lies between three quarters of the selected period and the whole period.

A control register picks one of four detection times and decides what an overflow raises. It can raise a single-cycle reset-request pulse or a single-cycle interrupt pulse. The watchdog needs no enable: it counts from reset release. While the low-power input is high, the prescaler and the counter both hold their values, and counting carries on from those values when the input drops. The counter restarts after each overflow, so a watchdog that keeps being ignored fires again once every full period.

Top module: `keyed_wdt`

## Requirements
- R1: After reset release the block counts with no write, using period code 00 and reset routing. The first `rst_req` pulse is high in the cycle that follows running clock edge 2^EXP0. Both outputs are low during reset.
- R2: A write of 0x4E (`CLR_KEY`) to address `CLR_ADDR` sets the binary counter to zero at that clock edge. A prescaler quarter boundary on the same edge is discarded.
- R3: Writing any value other than `CLR_KEY` to `CLR_ADDR` leaves the counter and the overflow time unchanged.
- R4: The clear does not touch the prescaler. Running edges are numbered from 1 after reset release, Q is the quarter length, and c is the clear edge. Overflow comes on running edge (floor(c/Q)+4)·Q, which lies 3Q+1 to 4Q running edges after the clear.
- R5: The control register at `CTRL_ADDR` uses bits [2:1] for the period code and bit 0 for the routing select. Select 1 sends an overflow to `rst_req` and select 0 sends it to `wdt_irq`. The select value held when the overflow occurs is the one that counts, and the two outputs are never high together.
- R6: Period codes 00, 01, 10 and 11 select detection times of 2^EXP0, 2^EXP1, 2^EXP2 and 2^EXP3 cycles. Each quarter is 2^(EXPn-2) cycles. With default parameters, code 10 gives 2^21 cycles.
- R7: While `lp_mode` is 1, the prescaler and the counter hold and no overflow occurs. Once `lp_mode` returns to 0, the remaining running cycles to overflow are the same as before.
- R8: Each output pulse lasts one cycle. After an overflow the counter restarts, so with no clear the next overflow follows 4Q running edges later.
- R9: A control write that changes the period code clears the counter, just as the key does. A control write with the same period code does not clear it.
- R10: Writes to any other address change neither the counter nor the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| lp_mode | input | 1 | Low-power mode active; freezes all counting |
| rst_req | output | 1 | Single-cycle reset request on overflow |
| wdt_irq | output | 1 | Single-cycle watchdog interrupt on overflow |

## Verification
The hardest situation to reach is a clear that lands at a chosen point inside a prescaler quarter, including a clear on the very edge of a quarter boundary. The prescaler phase cannot be seen at the ports. The bench therefore counts running edges from reset release itself. It places clear writes at offsets that sweep every phase of the shortest period and the ends and middle of the longer ones. It then predicts the exact overflow edge from that count. Low-power windows are placed between a clear and its overflow, so the prediction in running edges must still hold while the wall-clock arrival moves later by the length of the window.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   typedef logic [1:0] period_code_t;

   typedef struct packed {
      period_code_t period;
      logic         to_reset;
   } wdt_ctrl_t;

   localparam int CTRL_W = $bits(wdt_ctrl_t);

   function automatic int pick_exp(input int code, input int e0, input int e1,
                                   input int e2, input int e3);
      case (code)
         0:       return e0;
         1:       return e1;
         2:       return e2;
         default: return e3;
      endcase
   endfunction

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
   import wdt_pkg::*;
#(
   parameter int                  ADDR_W       = 4,
   parameter int                  DATA_W       = 8,
   parameter logic [ADDR_W-1:0]   CTRL_ADDR    = '0,
   parameter logic [ADDR_W-1:0]   CLR_ADDR     = 1,
   parameter logic [DATA_W-1:0]   CLR_KEY      = 8'h4E,
   parameter period_code_t        RST_PERIOD   = 2'b00,
   parameter logic                RST_TO_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output wdt_ctrl_t         ctrl,
   output logic              clr
);

   logic      ctrl_wr;
   logic      key_wr;
   logic      period_chg;
   wdt_ctrl_t ctrl_new;

   assign ctrl_wr    = wr_en && (wr_addr == CTRL_ADDR);
   assign key_wr     = wr_en && (wr_addr == CLR_ADDR) && (wr_data == CLR_KEY);
   assign ctrl_new   = wdt_ctrl_t'(wr_data[CTRL_W-1:0]);
   assign period_chg = ctrl_wr && (ctrl_new.period != ctrl.period);
   assign clr        = key_wr || period_chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl.period   <= RST_PERIOD;
         ctrl.to_reset <= RST_TO_RESET;
      end else if (ctrl_wr) begin
         ctrl <= ctrl_new;
      end
   end

   // R10: control only changes through its own address
   assert_ctrl_own_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_addr == CTRL_ADDR)) |=> $stable(ctrl));

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
   import wdt_pkg::*;
#(
   parameter int PW  = 23,
   parameter int QE0 = 23,
   parameter int QE1 = 21,
   parameter int QE2 = 19,
   parameter int QE3 = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  period_code_t code,
   output logic         tick
);

   logic [PW-1:0] pre;
   logic [3:0]    tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pre <= '0;
      else if (run) pre <= pre + 1'b1;
   end

   for (genvar g = 0; g < 4; g++) begin : g_tap
      localparam int            QE   = pick_exp(g, QE0, QE1, QE2, QE3);
      localparam logic [PW-1:0] MASK = PW'((64'd1 << QE) - 64'd1);
      assign tap[g] = ((pre & MASK) == MASK);
   end

   assign tick = run && tap[code];

   // R7: prescaler phase frozen in low-power mode
   assert_pre_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(pre));

   // R4: prescaler never restarted, advances every running cycle
   assert_pre_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> (pre == $past(pre) + 1'b1));

endmodule

// File: rtl/wdt_stage_cnt.sv
module wdt_stage_cnt #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);

   assign ovf = tick && !clr && (&cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end

   // R3: nothing but a tick or a clear moves the counter
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !tick) |=> $stable(cnt));

   // R8: counter restarts from zero after an overflow
   assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (cnt == '0));

endmodule

// File: rtl/wdt_route.sv
module wdt_route (
   input  logic clk,
   input  logic rst_n,
   input  logic ovf,
   input  logic to_reset,
   output logic rst_req,
   output logic wdt_irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req <= 1'b0;
         wdt_irq <= 1'b0;
      end else begin
         rst_req <= ovf && to_reset;
         wdt_irq <= ovf && !to_reset;
      end
   end

   // R5: routing follows the select held at overflow
   assert_route_rst_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> ($past(ovf) && $past(to_reset)));
   assert_route_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_irq |-> ($past(ovf) && !$past(to_reset)));
   assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rst_req, wdt_irq}));

   // R8: single-cycle pulses
   assert_single_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);
   assert_single_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_irq |=> !wdt_irq);

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
   import wdt_pkg::*;
#(
   parameter int                ADDR_W       = 4,
   parameter int                DATA_W       = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR    = '0,
   parameter logic [ADDR_W-1:0] CLR_ADDR     = 1,
   parameter logic [DATA_W-1:0] CLR_KEY      = 8'h4E,
   parameter int                EXP0         = 25,
   parameter int                EXP1         = 23,
   parameter int                EXP2         = 21,
   parameter int                EXP3         = 19,
   parameter int                CNT_W        = 2,
   parameter period_code_t      RST_PERIOD   = 2'b00,
   parameter logic              RST_TO_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              lp_mode,
   output logic              rst_req,
   output logic              wdt_irq
);

   localparam int QE0 = EXP0 - 2;
   localparam int QE1 = EXP1 - 2;
   localparam int QE2 = EXP2 - 2;
   localparam int QE3 = EXP3 - 2;
   localparam int PW  = max4(QE0, QE1, QE2, QE3);
   localparam int SW  = PW + 3;

   if (EXP0 < 3 || EXP1 < 3 || EXP2 < 3 || EXP3 < 3) begin : g_bad_exp
      $error("keyed_wdt: every period exponent must be at least 3");
   end
   if (PW > 40) begin : g_bad_width
      $error("keyed_wdt: period exponent too large");
   end
   if (CNT_W != 2) begin : g_bad_cnt
      $error("keyed_wdt: quarter scheme needs a two-bit stage counter");
   end
   if (DATA_W < CTRL_W) begin : g_bad_data
      $error("keyed_wdt: data bus narrower than control register");
   end
   if (CTRL_ADDR == CLR_ADDR) begin : g_bad_addr
      $error("keyed_wdt: control and clear addresses must differ");
   end

   wdt_ctrl_t        ctrl;
   logic             clr;
   logic             run;
   logic             tick;
   logic [CNT_W-1:0] cnt;
   logic             ovf;

   assign run = !lp_mode;

   wdt_regfile #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
      .CLR_ADDR(CLR_ADDR), .CLR_KEY(CLR_KEY),
      .RST_PERIOD(RST_PERIOD), .RST_TO_RESET(RST_TO_RESET)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ctrl(ctrl), .clr(clr)
   );

   wdt_prescaler #(
      .PW(PW), .QE0(QE0), .QE1(QE1), .QE2(QE2), .QE3(QE3)
   ) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .code(ctrl.period), .tick(tick)
   );

   wdt_stage_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .cnt(cnt), .ovf(ovf)
   );

   wdt_route u_route (
      .clk(clk), .rst_n(rst_n), .ovf(ovf), .to_reset(ctrl.to_reset),
      .rst_req(rst_req), .wdt_irq(wdt_irq)
   );

   // ---------------- checking logic ----------------
   logic [SW-1:0] since_clr;
   logic [SW-1:0] q_len;
   int            qe_cur;

   always_comb begin
      qe_cur = pick_exp(int'(ctrl.period), QE0, QE1, QE2, QE3);
      q_len  = SW'(1) << qe_cur;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_clr <= '0;
      else if (clr || ovf)     since_clr <= '0;
      else if (run)            since_clr <= since_clr + 1'b1;
   end

   // R4: overflow only inside the three-quarter to full-period window
   assert_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> ((since_clr >= (q_len << 1) + q_len) && (since_clr < (q_len << 2))));

   // R2: key write clears the counter
   assert_clear_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == CLR_ADDR) && (wr_data == CLR_KEY)) |=> (cnt == '0));

   // R3: wrong key leaves the counter alone
   assert_wrong_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == CLR_ADDR) && (wr_data != CLR_KEY) && !tick)
      |=> $stable(cnt));

   // R10: foreign addresses leave the counter alone
   assert_foreign_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr != CLR_ADDR) && (wr_addr != CTRL_ADDR) && !tick)
      |=> $stable(cnt));

   // R7: counter frozen in low-power mode unless cleared
   assert_cnt_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_mode && !clr) |=> $stable(cnt));

   // R9: period change acts as a clear
   assert_period_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == CTRL_ADDR) && (wr_data[2:1] != ctrl.period))
      |=> (cnt == '0));

endmodule

// File: tb/keyed_wdt_tb.sv
`timescale 1ns/1ps
module keyed_wdt_tb;

   localparam int E0 = 10, E1 = 8, E2 = 6, E3 = 4;
   localparam logic [3:0] A_CTRL  = 4'h0;
   localparam logic [3:0] A_CLR   = 4'h1;
   localparam logic [3:0] A_OTHER = 4'h9;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       lp_mode = 1'b0;
   logic       rst_req;
   logic       wdt_irq;

   int  n_tests = 0, n_fail = 0;
   int  run_edges = 0, abs_edges = 0;
   int  pulse_cnt = 0, last_edge = 0, last_abs = 0, last_kind = 0;
   int  width_err = 0, both_err = 0, base_cnt = 0;
   bit  prev_hi = 1'b0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   keyed_wdt #(.EXP0(E0), .EXP1(E1), .EXP2(E2), .EXP3(E3)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .lp_mode(lp_mode), .rst_req(rst_req), .wdt_irq(wdt_irq)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         run_edges = 0;
         abs_edges = 0;
      end else begin
         abs_edges++;
         if (!lp_mode) run_edges++;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (rst_req || wdt_irq) begin
            pulse_cnt++;
            last_edge = run_edges;
            last_abs  = abs_edges;
            last_kind = rst_req ? 1 : 0;
            if (prev_hi) width_err++;
            if (rst_req && wdt_irq) both_err++;
         end
         prev_hi = rst_req || wdt_irq;
      end
   end

   function automatic int qof(input int code);
      case (code)
         0: return 1 << (E0 - 2);
         1: return 1 << (E1 - 2);
         2: return 1 << (E2 - 2);
         default: return 1 << (E3 - 2);
      endcase
   endfunction

   function automatic int pred(input int c, input int q);
      return (c / q + 4) * q;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d, output int c, output int ca);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      c  = run_edges + (lp_mode ? 0 : 1);
      ca = abs_edges + 1;
      @(negedge clk);
      wr_en = 1'b0;
      #1 base_cnt = pulse_cnt;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_pulse(input int exp_edge, input int exp_kind,
                               input string req, input string what);
      int guard;
      guard = 0;
      while (pulse_cnt == base_cnt && guard < 3000) begin
         @(negedge clk);
         #1 guard++;
      end
      check(pulse_cnt == base_cnt + 1, req, {what, " pulse count"}, pulse_cnt - base_cnt, 1);
      check(last_edge == exp_edge, req, {what, " overflow edge"}, last_edge, exp_edge);
      check(last_kind == exp_kind, req, {what, " output kind"}, last_kind, exp_kind);
      base_cnt = pulse_cnt;
   endtask

   initial begin
      int c, ca, c2, ca2, q, e, gap;
      // R1: reset state
      idle(4);
      #1;
      check(rst_req == 1'b0 && wdt_irq == 1'b0, "R1", "outputs in reset",
            int'(rst_req) + int'(wdt_irq), 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(20);
      #1;
      check(pulse_cnt == 0, "R1", "no early pulse", pulse_cnt, 0);
      // R1: first overflow with no software action, code 00, reset routing
      base_cnt = 0;
      expect_pulse(4 * qof(0), 1, "R1", "first overflow");

      // R5/R6/R9: byte 0000_1101 selects code 10 and reset routing
      wr(A_CTRL, 8'b0000_1101, c, ca);
      expect_pulse(pred(c, qof(2)), 1, "R6", "code 10 example");

      // R2/R4/R5/R6: sweep codes, selects and clear phases
      for (int code = 0; code < 4; code++) begin
         for (int sel = 0; sel < 2; sel++) begin
            q = qof(code);
            for (int k = 0; k < ((code == 3) ? 8 : 4); k++) begin
               int off;
               if (code == 3) off = k;
               else off = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? q / 2 : q - 1;
               wr(A_CTRL, 8'(code * 2 + sel), c, ca);
               idle(off);
               wr(A_CLR, 8'h4E, c, ca);
               e = pred(c, q);
               expect_pulse(e, sel, "R2", "sweep clear");
               gap = last_edge - c;
               check(gap >= 3 * q + 1 && gap <= 4 * q, "R4", "clear-to-overflow window",
                     gap, 4 * q);
            end
         end
      end

      // R3/R10: wrong keys and foreign addresses do not clear
      wr(A_CTRL, 8'b0000_0100, c, ca);
      wr(A_CLR, 8'h4E, c, ca);
      idle(20);
      wr(A_CLR, 8'h4F, c2, ca2);
      wr(A_CLR, 8'h00, c2, ca2);
      wr(A_CLR, 8'hE4, c2, ca2);
      wr(A_CLR, 8'hFF, c2, ca2);
      expect_pulse(pred(c, qof(2)), 0, "R3", "wrong key ignored");
      wr(A_CLR, 8'h4E, c, ca);
      idle(25);
      wr(A_OTHER, 8'h4E, c2, ca2);
      wr(A_OTHER, 8'h07, c2, ca2);
      expect_pulse(pred(c, qof(2)), 0, "R10", "foreign address ignored");

      // R9: same period keeps count, routing follows select at overflow (R5)
      wr(A_CLR, 8'h4E, c, ca);
      idle(30);
      wr(A_CTRL, 8'b0000_0101, c2, ca2);
      expect_pulse(pred(c, qof(2)), 1, "R9", "same period no clear");
      // R9: period change clears
      wr(A_CLR, 8'h4E, c, ca);
      idle(40);
      wr(A_CTRL, 8'b0000_0111, c2, ca2);
      expect_pulse(pred(c2, qof(3)), 1, "R9", "period change clears");

      // R7: low-power window freezes counting
      wr(A_CTRL, 8'b0000_0101, c, ca);
      wr(A_CLR, 8'h4E, c, ca);
      idle(10);
      lp_mode = 1'b1;
      idle(37);
      lp_mode = 1'b0;
      e = pred(c, qof(2));
      expect_pulse(e, 1, "R7", "low-power run edges");
      check(last_abs == ca + (e - c) + 37, "R7", "low-power wall-clock delay",
            last_abs, ca + (e - c) + 37);

      // R8: repeated interrupt without clear, single-cycle pulses
      wr(A_CTRL, 8'b0000_0110, c, ca);
      wr(A_CLR, 8'h4E, c, ca);
      e = pred(c, qof(3));
      expect_pulse(e, 0, "R8", "first interrupt");
      expect_pulse(e + 4 * qof(3), 0, "R8", "repeat interrupt");
      check(width_err == 0, "R8", "multi-cycle pulses", width_err, 0);
      check(both_err == 0, "R5", "both outputs high", both_err, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R1 watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule